// File: doc/BRIEF.md
# Register-Bank Serial Slave with Coherent Result Snapshot

This block sits on a two-wire I2C-compatible bus and lets a host reach a small register bank. A fast system clock samples SCL and SDA. The block detects start, repeated-start and stop conditions and matches the 7-bit device address. It acknowledges by pulling SDA low through an open-drain enable, and it keeps an 8-bit register pointer that loads, advances and clears.

The register storage itself lives beside the block. The block issues a one-cycle write strobe with address and data, presents a read address, and takes the returned byte. A multi-byte conversion result enters as one live vector. The block captures that vector into a shadow copy whenever a read transfer is addressed. Every result byte read within one transfer therefore comes from the same result, even if a fresh result lands part way through.

The default map spans 0x00 to 0x12. Address 0x00 is a read-only status byte, 0x01 to 0x06 hold the six result bytes, and 0x07 to 0x12 are writable.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After a start condition, the first byte is shifted in MSB first. Its upper seven bits must equal 0x48, so the byte is 0x90 for a write or 0x91 for a read. On a match the slave drives SDA low in the ninth clock. Any other address gets no acknowledge, and the slave ignores the rest of that transfer.
- R2: In a write transfer, the byte after the address byte is loaded into the pointer and acknowledged. It produces no write strobe.
- R3: Each further write byte is acknowledged and produces exactly one single-cycle strobe carrying the current pointer and the byte. The pointer then advances by one.
- R4: A write byte aimed at 0x00, at the result range 0x01–0x06, or at any address above 0x12 is still acknowledged. It produces no strobe, so the stored contents read back unchanged.
- R5: A read transfer sends the byte at the current pointer, MSB first. Each master acknowledge advances the pointer, and the next byte follows.
- R6: A master no-acknowledge ends the read without advancing the pointer. A repeated start followed by a read then returns the same byte again.
- R7: Reads that run past 0x12 keep returning whatever the register side gives at each following address. The 8-bit pointer wraps from 0xFF to 0x00.
- R8: Every stop condition clears the pointer to 0x00, so a bare read after a stop returns the status byte.
- R9: A repeated start behaves like a start. A pointer write, then a repeated start, then a read address reads from the new pointer.
- R10: Address 0x01+k returns result byte k, where byte 0 is the most significant byte of the result vector. The result is captured when a read address is accepted. A change to the live result during that transfer is seen only in a later transfer.
- R11: The slave changes its SDA enable only while the synchronized SCL is low. An SDA change while SCL is low is data, never a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_wr_en | output | 1 | One-cycle write strobe to the register bank |
| reg_wr_addr | output | 8 | Register address for the strobe |
| reg_wr_data | output | 8 | Byte to store |
| reg_rd_addr | output | 8 | Current pointer, used as the read address |
| reg_rd_data | input | 8 | Byte returned for reg_rd_addr |
| res_live | input | RES_BYTES*8 | Live conversion result, byte 0 in the top bits |

## Verification
A wrong pointer shows up in the first byte the master reads after the fault. Data goes missing or repeats one byte later, or the status byte does not come back after a stop. A bit-counter or state slip shifts the acknowledge by one clock, so the very next address or data byte sees a missing acknowledge or a byte rotated by one bit. A bad snapshot shows only when the live result changes mid-transfer: the bytes after the change come back with the new value, within the same read. A misplaced enable edge appears as SDA moving while SCL is high, which a monitor at the pins flags in the same bus cycle.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK_WAIT,
      ST_ACK_HOLD,
      ST_TX,
      ST_RACK,
      ST_RACK_WAIT
   } bus_state_t;

   typedef enum logic [1:0] {
      K_ADDR,
      K_PTR,
      K_DATA
   } byte_kind_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d;
   logic              sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_d <= scl_q[LAST];
         sda_d <= sda_q[LAST];
      end
   end

   assign scl_s     = scl_q[LAST];
   assign sda_s     = sda_q[LAST];
   assign scl_rise  =  scl_s & ~scl_d;
   assign scl_fall  = ~scl_s &  scl_d;
   assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
   assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/i2c_rb_snapshot.sv
module i2c_rb_snapshot #(
   parameter int unsigned RES_BASE  = 1,
   parameter int unsigned RES_BYTES = 6,
   parameter bit          SNAP_EN   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cap,
   input  logic [RES_BYTES*8-1:0] live,
   input  logic [7:0]             ptr,
   input  logic [7:0]             ext_data,
   output logic [7:0]             rd_byte
);
   localparam int unsigned VEC_W = RES_BYTES * 8;

   logic [VEC_W-1:0] held;
   logic [7:0]       lane [RES_BYTES];
   logic [7:0]       off;
   logic             in_res;

   generate
      if (SNAP_EN) begin : g_shadow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   held <= '0;
            else if (cap) held <= live;
         end
      end else begin : g_direct
         logic unused_cap;
         assign unused_cap = cap;
         assign held = live;
      end
   endgenerate

   for (genvar g = 0; g < RES_BYTES; g++) begin : g_lane
      assign lane[g] = held[(RES_BYTES-1-g)*8 +: 8];
   end

   assign off    = ptr - 8'(RES_BASE);
   assign in_res = (ptr >= 8'(RES_BASE)) && (off < 8'(RES_BYTES));

   always_comb begin
      rd_byte = ext_data;
      if (in_res) begin
         for (int k = 0; k < RES_BYTES; k++) begin
            if (off == 8'(k)) rd_byte = lane[k];
         end
      end
   end

endmodule

// File: rtl/i2c_rb_wrgate.sv
module i2c_rb_wrgate #(
   parameter int unsigned WR_FIRST = 7,
   parameter int unsigned MAP_LAST = 18
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic [7:0] addr,
   input  logic [7:0] data,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data
);
   logic writable;

   assign writable = (addr >= 8'(WR_FIRST)) && (addr <= 8'(MAP_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= req & writable;
         if (req) begin
            wr_addr <= addr;
            wr_data <= data;
         end
      end
   end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
   import i2c_rb_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h48,
   parameter int unsigned MAP_LAST    = 18,
   parameter int unsigned WR_FIRST    = 7,
   parameter int unsigned RES_BASE    = 1,
   parameter int unsigned RES_BYTES   = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SNAP_EN     = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe,
   output logic                   reg_wr_en,
   output logic [7:0]             reg_wr_addr,
   output logic [7:0]             reg_wr_data,
   output logic [7:0]             reg_rd_addr,
   input  logic [7:0]             reg_rd_data,
   input  logic [RES_BYTES*8-1:0] res_live
);
   localparam int unsigned RES_LAST = RES_BASE + RES_BYTES - 1;

   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be 2 or more");
      assert (RES_BYTES >= 1 && RES_LAST < WR_FIRST)
         else $error("result window must sit below the writable window");
      assert (WR_FIRST <= MAP_LAST && MAP_LAST < 256)
         else $error("writable window must lie inside an 8-bit map");
   end

   logic scl_s, scl_rise, scl_fall, start_det, stop_det;
   logic sda_s;

   i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // the data line sampled at the same depth as the clock line
   logic [SYNC_STAGES-1:0] sda_pipe;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_pipe <= '1;
      else        sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
   end
   assign sda_s = sda_pipe[SYNC_STAGES-1];

   bus_state_t state;
   byte_kind_t kind;
   logic [2:0] bitcnt;
   logic [7:0] shreg, tx, ptr, wr_addr_q;
   logic       rw, wr_req, snap_cap;
   logic [7:0] rx_byte, rd_byte;

   assign rx_byte = {shreg[6:0], sda_s};

   i2c_rb_snapshot #(
      .RES_BASE  (RES_BASE),
      .RES_BYTES (RES_BYTES),
      .SNAP_EN   (SNAP_EN)
   ) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (snap_cap),
      .live     (res_live),
      .ptr      (ptr),
      .ext_data (reg_rd_data),
      .rd_byte  (rd_byte)
   );

   i2c_rb_wrgate #(
      .WR_FIRST (WR_FIRST),
      .MAP_LAST (MAP_LAST)
   ) u_wrgate (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (wr_req),
      .addr    (wr_addr_q),
      .data    (shreg),
      .wr_en   (reg_wr_en),
      .wr_addr (reg_wr_addr),
      .wr_data (reg_wr_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= K_ADDR;
         bitcnt    <= '0;
         shreg     <= '0;
         tx        <= '0;
         ptr       <= '0;
         wr_addr_q <= '0;
         rw        <= 1'b0;
         wr_req    <= 1'b0;
         snap_cap  <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         wr_req   <= 1'b0;
         snap_cap <= 1'b0;
         if (stop_det) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state  <= ST_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: if (scl_rise) begin
                  shreg <= rx_byte;
                  if (bitcnt == 3'd7) begin
                     bitcnt <= '0;
                     unique case (kind)
                        K_ADDR: begin
                           if (rx_byte[7:1] == DEV_ADDR) begin
                              rw       <= rx_byte[0];
                              snap_cap <= rx_byte[0];
                              state    <= ST_ACK_WAIT;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        K_PTR: begin
                           ptr   <= rx_byte;
                           state <= ST_ACK_WAIT;
                        end
                        default: begin
                           wr_req    <= 1'b1;
                           wr_addr_q <= ptr;
                           ptr       <= ptr + 8'd1;
                           state     <= ST_ACK_WAIT;
                        end
                     endcase
                  end else begin
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
               ST_ACK_WAIT: if (scl_fall) begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK_HOLD;
               end
               ST_ACK_HOLD: if (scl_fall) begin
                  if (kind == K_ADDR && rw) begin
                     tx     <= rd_byte;
                     sda_oe <= ~rd_byte[7];
                     bitcnt <= '0;
                     state  <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
                     state  <= ST_RX;
                  end
               end
               ST_TX: if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else begin
                     tx     <= {tx[6:0], 1'b0};
                     sda_oe <= ~tx[6];
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
               ST_RACK: if (scl_rise) begin
                  if (!sda_s) begin
                     ptr   <= ptr + 8'd1;
                     state <= ST_RACK_WAIT;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_RACK_WAIT: if (scl_fall) begin
                  tx     <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                  bitcnt <= '0;
                  state  <= ST_TX;
               end
               default: ;
            endcase
         end
      end
   end

   assign reg_rd_addr = ptr;

endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk #(
   parameter int unsigned WR_FIRST = 7,
   parameter int unsigned MAP_LAST = 18
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       stop_det,
   input logic       snap_cap,
   input logic       sda_oe,
   input logic       reg_wr_en,
   input logic [7:0] reg_wr_addr,
   input logic [7:0] reg_rd_addr
);
   // R11: the pull-down enable only moves in the clock-low half
   a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R4: a strobe never reaches a read-only or unmapped address
   a_r4_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (reg_wr_addr >= 8'(WR_FIRST) && reg_wr_addr <= 8'(MAP_LAST)));

   // R3: one strobe per data byte
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   // R8: a stop leaves the pointer at zero
   a_r8_stop_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (reg_rd_addr == 8'h00));

   // R10: capture is a single pulse taken while the clock line is high
   a_r10_capture_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      snap_cap |=> !snap_cap);

endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(
   .WR_FIRST (WR_FIRST),
   .MAP_LAST (MAP_LAST)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_s       (scl_s),
   .stop_det    (stop_det),
   .snap_cap    (snap_cap),
   .sda_oe      (sda_oe),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_addr (reg_wr_addr),
   .reg_rd_addr (reg_rd_addr)
);

// File: tb/i2c_regbank_slave_tb.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda_low = 1'b0;
   logic        sda_line;
   logic        sda_oe, reg_wr_en;
   logic [7:0]  reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;
   logic [47:0] res_live = 48'hA1A2A3A4A5A6;
   logic [7:0]  regs [256];
   logic [7:0]  rbuf [8];

   int n_chk = 0, n_err = 0, wr_cnt = 0, r11_viol = 0;
   logic prev_oe = 1'b0;

   always #2 clk = ~clk;

   assign sda_line    = ~(m_sda_low | sda_oe);
   assign reg_rd_data = regs[reg_rd_addr];

   i2c_regbank_slave u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (m_scl),
      .sda_i       (sda_line),
      .sda_oe      (sda_oe),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_addr (reg_wr_addr),
      .reg_wr_data (reg_wr_data),
      .reg_rd_addr (reg_rd_addr),
      .reg_rd_data (reg_rd_data),
      .res_live    (res_live)
   );

   // register-bank model: preset value is address xor 0x5A
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) regs[i] <= 8'(i) ^ 8'h5A;
      end else if (reg_wr_en) begin
         regs[reg_wr_addr] <= reg_wr_data;
      end
   end

   // pin monitors
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr_en) wr_cnt <= wr_cnt + 1;
         if (sda_oe != prev_oe && m_scl) r11_viol <= r11_viol + 1;
      end
      prev_oe <= sda_oe;
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_cycle(input logic low, output logic seen);
      waitc(10); m_sda_low = low;
      waitc(10); m_scl = 1'b1;
      waitc(10); seen = sda_line;
      waitc(10); m_scl = 1'b0;
   endtask

   task automatic bus_start;
      waitc(10); m_sda_low = 1'b1;
      waitc(10); m_scl = 1'b0;
   endtask

   task automatic bus_rstart;
      waitc(10); m_sda_low = 1'b0;
      waitc(10); m_scl = 1'b1;
      waitc(10); m_sda_low = 1'b1;
      waitc(10); m_scl = 1'b0;
   endtask

   task automatic bus_stop;
      waitc(10); m_sda_low = 1'b1;
      waitc(10); m_scl = 1'b1;
      waitc(10); m_sda_low = 1'b0;
      waitc(20);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) bit_cycle(~b[i], s);
      bit_cycle(1'b0, s);
      acked = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      m_sda_low = 1'b0;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         bit_cycle(1'b0, s);
         d = {d[6:0], s};
      end
      bit_cycle(give_ack, s);
   endtask

   // pointer write, repeated start, read n bytes, stop; returns acks seen
   task automatic read_at(input logic [7:0] p, input int n, output int acks);
      logic a;
      acks = 0;
      bus_start;
      send_byte(8'h90, a); acks += int'(a);
      send_byte(p, a);     acks += int'(a);
      bus_rstart;
      send_byte(8'h91, a); acks += int'(a);
      for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
      bus_stop;
   endtask

   task automatic write_one(input logic [7:0] p, input logic [7:0] d, output int acks);
      logic a;
      acks = 0;
      bus_start;
      send_byte(8'h90, a); acks += int'(a);
      send_byte(p, a);     acks += int'(a);
      send_byte(d, a);     acks += int'(a);
      bus_stop;
   endtask

   // {address, byte written, byte expected on read-back}
   localparam logic [23:0] TBL [6] = '{
      {8'h07, 8'h11, 8'h11},
      {8'h12, 8'h22, 8'h22},
      {8'h00, 8'h33, 8'h5A},
      {8'h13, 8'h44, 8'h49},
      {8'h03, 8'h55, 8'hA3},
      {8'h0C, 8'h66, 8'h66}
   };

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : p_main
      int  acks;
      logic a;
      waitc(5);
      rst_n = 1'b1;
      waitc(5);
      chk("reset sda_oe", sda_oe, 0);
      chk("reset wr_en", reg_wr_en, 0);
      chk("reset R8 pointer", reg_rd_addr, 0);

      // table: R3 store, R4 ignored targets, R9 pointer+Sr read, R10 byte order
      for (int i = 0; i < 6; i++) begin
         write_one(TBL[i][23:16], TBL[i][15:8], acks);
         chk("R1 R4 write acks", 32'(acks), 3);
         read_at(TBL[i][23:16], 1, acks);
         chk("R9 read acks", 32'(acks), 3);
         chk("R3 R4 R10 read-back", rbuf[0], TBL[i][7:0]);
      end
      chk("R4 strobe count after table", 32'(wr_cnt), 3);

      // R1: foreign address is not acknowledged and the transfer is ignored
      bus_start;
      send_byte(8'hA0, a);
      chk("R1 foreign address nack", a, 0);
      send_byte(8'h07, a);
      send_byte(8'h99, a);
      bus_stop;
      chk("R1 no strobe for foreign", 32'(wr_cnt), 3);
      read_at(8'h07, 1, acks);
      chk("R1 contents intact", rbuf[0], 8'h11);

      // R2: pointer-only write stores nothing
      bus_start;
      send_byte(8'h90, a);
      send_byte(8'h09, a);
      chk("R2 pointer byte acked", a, 1);
      bus_stop;
      chk("R2 no strobe", 32'(wr_cnt), 3);
      read_at(8'h09, 1, acks);
      chk("R2 target unchanged", rbuf[0], 8'h53);

      // R3/R5: burst write then burst read
      bus_start;
      send_byte(8'h90, a);
      send_byte(8'h08, a);
      send_byte(8'h81, a);
      send_byte(8'h82, a);
      send_byte(8'h83, a);
      chk("R3 last data acked", a, 1);
      bus_stop;
      chk("R3 three strobes", 32'(wr_cnt), 6);
      read_at(8'h08, 3, acks);
      chk("R5 byte0", rbuf[0], 8'h81);
      chk("R5 byte1", rbuf[1], 8'h82);
      chk("R5 byte2", rbuf[2], 8'h83);

      // R6: nack leaves pointer in place across a repeated start
      bus_start;
      send_byte(8'h90, a);
      send_byte(8'h08, a);
      bus_rstart;
      send_byte(8'h91, a);
      recv_byte(1'b0, rbuf[0]);
      bus_rstart;
      send_byte(8'h91, a);
      recv_byte(1'b0, rbuf[1]);
      bus_stop;
      chk("R6 first read", rbuf[0], 8'h81);
      chk("R6 no advance after nack", rbuf[1], 8'h81);

      // R8: bare reads after stop return status, twice
      for (int r = 0; r < 2; r++) begin
         bus_start;
         send_byte(8'h91, a);
         recv_byte(1'b0, rbuf[0]);
         bus_stop;
         chk("R8 status poll", rbuf[0], 8'h5A);
      end

      // R7: run past the map, then wrap
      read_at(8'h11, 4, acks);
      chk("R7 0x11", rbuf[0], 8'h4B);
      chk("R7 0x12", rbuf[1], 8'h22);
      chk("R7 0x13", rbuf[2], 8'h49);
      chk("R7 0x14", rbuf[3], 8'h4E);
      read_at(8'hFE, 3, acks);
      chk("R7 0xFE", rbuf[0], 8'hA4);
      chk("R7 0xFF", rbuf[1], 8'hA5);
      chk("R7 wrap to 0x00", rbuf[2], 8'h5A);

      // R10: live result changes mid-transfer
      bus_start;
      send_byte(8'h90, a);
      send_byte(8'h01, a);
      bus_rstart;
      send_byte(8'h91, a);
      recv_byte(1'b1, rbuf[0]);
      res_live = 48'hB1B2B3B4B5B6;
      for (int k = 1; k < 6; k++) recv_byte(k < 5, rbuf[k]);
      bus_stop;
      chk("R10 byte0 old", rbuf[0], 8'hA1);
      chk("R10 byte1 old", rbuf[1], 8'hA2);
      chk("R10 byte5 old", rbuf[5], 8'hA6);
      read_at(8'h01, 6, acks);
      chk("R10 next transfer byte0", rbuf[0], 8'hB1);
      chk("R10 next transfer byte5", rbuf[5], 8'hB6);

      chk("R11 enable moved with SCL high", 32'(r11_viol), 0);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule